// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block controls one bank of general-purpose pins, organised as four ports of eight pins each. Software reaches it over a simple 32-bit register bus with a write strobe and a combinational read path. For every port it keeps three control registers: one that hands each pin to GPIO control or leaves it with its special function, one for output drive enable, and one for output level. The pins are exported as flat vectors. The external pin levels pass through a two-flop synchroniser and can be read back as a read-only input register.

Each pin can raise an interrupt. Detection can be by level, by one configured edge, or by any change. Detection results land in sticky status bits. Software clears those bits by writing ones to a separate clear register. A status bit is pending only when its enable bit is also set, and all 32 pins share a single bank interrupt line. Masked-write aliases let software update a subset of pins in one write, with no read-modify-write sequence.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register is zero. pin_out, pin_oe and pin_gpio_mode are zero and bank_irq is low.
- R2: Address bits [7:4] select the register kind and bits [3:2] select the port. Bits [1:0] are ignored. The kinds are: 0x0 mode, 0x1 output enable, 0x2 output value, 0x3 input, 0x4 status, 0x5 interrupt enable, 0x6 trigger, 0x7 clear. A plain write replaces the addressed register in the same clock edge, and a read returns it in bits [7:0].
- R3: A mode bit of 1 places pin p of port n under GPIO control. Mode, output enable and output value of port n appear on bits [8n+7:8n] of pin_gpio_mode, pin_oe and pin_out.
- R4: The input register of port n returns pin_in[8n+7:8n] two clock edges after the pins change. Writes to it have no effect.
- R5: The trigger register holds polarity in bits [7:0] (1 = high or rising, 0 = low or falling), the edge-versus-level select in bits [15:8] (1 = edge), and any-change select in bits [23:16]. In level mode, a status bit is set on every edge while the synchronised pin equals its polarity.
- R6: In edge mode with any-change off, only the transition selected by polarity sets status. The status bit is set on the third clock edge after the pin changes.
- R7: In edge mode with any-change on, both rising and falling transitions set status.
- R8: Writing 1 to a clear-register bit clears that status bit, and writing 0 leaves it unchanged. The clear register reads as zero. A detection in the same cycle wins over the clear.
- R9: Status is set whether or not the pin is enabled. bank_irq is high exactly when some pin has both its status bit and its enable bit set.
- R10: Writes to kinds 0x8, 0x9, 0xA, 0xC and 0xD update mode, output enable, output value, status and interrupt enable. Only pins whose mask bit in wdata[15:8] is 1 are updated, and they take the data in wdata[7:0]. Reads at these addresses return the plain register.
- R11: A write to kind 0xE uses wdata[31:24] as the pin mask. For each masked pin it updates all three trigger fields from wdata[23:0].
- R12: Kinds 0xB and 0xF read zero and writes to them have no effect. Trigger bits [31:24] always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Asynchronous pin levels, port n on bits [8n+7:8n] |
| pin_out | output | 32 | Output levels |
| pin_oe | output | 32 | Output drive enables |
| pin_gpio_mode | output | 32 | 1 = pin under GPIO control |
| bank_irq | output | 1 | Combined bank interrupt |

## Verification
The assertions watch port 0 on every cycle:
- the input read path matches the pins as they were two cycles earlier;
- plain and masked writes to the output value land exactly as written;
- a clear write removes status unless a detection coincides;
- a status bit never rises without a detection or a masked status write;
- unmapped addresses read zero.

Only the bench's scenarios show the following: the level, single-edge and any-change detection modes with their exact three-edge latency; the masked trigger alias; the independence of status from enable; and the address map across all four ports.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
// Shared register-kind encoding for the GPIO bank.
// Assumes the kind sits in address bits [7:4]; the values are part of the map.
package gpio_bank_pkg;

    typedef enum logic [3:0] {
        RK_MODE    = 4'h0,
        RK_DRIVE   = 4'h1,
        RK_LEVEL   = 4'h2,
        RK_INPUT   = 4'h3,
        RK_STATUS  = 4'h4,
        RK_ENABLE  = 4'h5,
        RK_TRIG    = 4'h6,
        RK_CLEAR   = 4'h7,
        RK_MODE_M  = 4'h8,
        RK_DRIVE_M = 4'h9,
        RK_LEVEL_M = 4'hA,
        RK_HOLE_B  = 4'hB,
        RK_STAT_M  = 4'hC,
        RK_ENAB_M  = 4'hD,
        RK_TRIG_M  = 4'hE,
        RK_HOLE_F  = 4'hF
    } reg_kind_e;

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for asynchronous pin levels, plus one extra
// register holding the synchronised value of the previous cycle.
// Assumes each pin is an independent level (no bus coherency needed).
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_q,
    output logic [WIDTH-1:0] sync_prev
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the pin levels through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    // Remember last cycle's synchronised level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_prev <= '0;
        else        sync_prev <= chain[STAGES-1];
    end

    assign sync_q = chain[STAGES-1];

endmodule

// File: rtl/gpio_trig_detect.sv
`timescale 1ns/1ps
// Per-pin trigger evaluation for one port: level, single edge or any edge.
// Assumes cur/prev are synchronised levels one cycle apart.
module gpio_trig_detect #(
    parameter int PINS = 8
) (
    input  logic [PINS-1:0] cur,
    input  logic [PINS-1:0] prev,
    input  logic [PINS-1:0] pol,
    input  logic [PINS-1:0] edg,
    input  logic [PINS-1:0] anyc,
    output logic [PINS-1:0] evt
);

    genvar p;
    generate
        for (p = 0; p < PINS; p++) begin : g_pin
            logic rise, fall, edge_hit, lvl_hit;
            // Classify the transition and apply the pin's trigger fields.
            always_comb begin
                rise     = cur[p] & ~prev[p];
                fall     = ~cur[p] & prev[p];
                edge_hit = anyc[p] ? (rise | fall) : (pol[p] ? rise : fall);
                lvl_hit  = (cur[p] == pol[p]);
                evt[p]   = edg[p] ? edge_hit : lvl_hit;
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
// Register set of one port: mode, drive, level, enable, trigger fields and
// sticky status. Handles plain, masked and write-one-to-clear writes.
// Assumes the decoder raises wr_hit only for this port; 4*PINS <= DATA_W.
module gpio_port_regs
    import gpio_bank_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  reg_kind_e         kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PINS-1:0]   evt,
    output logic [PINS-1:0]   mode_q,
    output logic [PINS-1:0]   drive_q,
    output logic [PINS-1:0]   level_q,
    output logic [PINS-1:0]   enab_q,
    output logic [PINS-1:0]   stat_q,
    output logic [PINS-1:0]   pol_q,
    output logic [PINS-1:0]   edg_q,
    output logic [PINS-1:0]   anyc_q
);

    logic [PINS-1:0] dat, msk, tmsk;
    logic [PINS-1:0] f_pol, f_edg, f_any;
    logic [PINS-1:0] stat_nx;

    assign dat   = wdata[PINS-1:0];
    assign msk   = wdata[2*PINS-1:PINS];
    assign f_pol = wdata[PINS-1:0];
    assign f_edg = wdata[2*PINS-1:PINS];
    assign f_any = wdata[3*PINS-1:2*PINS];
    assign tmsk  = wdata[4*PINS-1:3*PINS];

    // Mode, drive, level and enable: plain replace or masked merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            drive_q <= '0;
            level_q <= '0;
            enab_q  <= '0;
        end else if (wr_hit) begin
            case (kind)
                RK_MODE:    mode_q  <= dat;
                RK_MODE_M:  mode_q  <= (mode_q  & ~msk) | (dat & msk);
                RK_DRIVE:   drive_q <= dat;
                RK_DRIVE_M: drive_q <= (drive_q & ~msk) | (dat & msk);
                RK_LEVEL:   level_q <= dat;
                RK_LEVEL_M: level_q <= (level_q & ~msk) | (dat & msk);
                RK_ENABLE:  enab_q  <= dat;
                RK_ENAB_M:  enab_q  <= (enab_q  & ~msk) | (dat & msk);
                default:    ;
            endcase
        end
    end

    // Trigger fields: all three at once, or per pin under the top-byte mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            edg_q  <= '0;
            anyc_q <= '0;
        end else if (wr_hit && kind == RK_TRIG) begin
            pol_q  <= f_pol;
            edg_q  <= f_edg;
            anyc_q <= f_any;
        end else if (wr_hit && kind == RK_TRIG_M) begin
            pol_q  <= (pol_q  & ~tmsk) | (f_pol & tmsk);
            edg_q  <= (edg_q  & ~tmsk) | (f_edg & tmsk);
            anyc_q <= (anyc_q & ~tmsk) | (f_any & tmsk);
        end
    end

    // Status next state: clear or masked write first, detections win last.
    always_comb begin
        stat_nx = stat_q;
        if (wr_hit && kind == RK_CLEAR)  stat_nx = stat_nx & ~dat;
        if (wr_hit && kind == RK_STAT_M) stat_nx = (stat_nx & ~msk) | (dat & msk);
        stat_nx = stat_nx | evt;
    end

    // Register the sticky status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_nx;
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
`timescale 1ns/1ps
// GPIO bank of NUM_PORTS ports x PINS pins with register bus, input
// synchroniser, per-pin interrupt detection and one bank interrupt line.
// Assumes address bits [7:4] = register kind, [3:2] = port; NUM_PORTS <= 4.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int PINS        = 8,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr_en,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NUM_PORTS*PINS-1:0] pin_in,
    output logic [NUM_PORTS*PINS-1:0] pin_out,
    output logic [NUM_PORTS*PINS-1:0] pin_oe,
    output logic [NUM_PORTS*PINS-1:0] pin_gpio_mode,
    output logic                      bank_irq
);

    localparam int TOTAL  = NUM_PORTS * PINS;
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    reg_kind_e         kind;
    logic [PORT_W-1:0] port_sel;
    logic [TOTAL-1:0]  pin_now, pin_last;
    logic [TOTAL-1:0]  sta_flat, enb_flat, evt_flat;
    logic              unused_addr_bits;

    logic [PINS-1:0] mode_a [NUM_PORTS];
    logic [PINS-1:0] drv_a  [NUM_PORTS];
    logic [PINS-1:0] lvl_a  [NUM_PORTS];
    logic [PINS-1:0] enb_a  [NUM_PORTS];
    logic [PINS-1:0] sta_a  [NUM_PORTS];
    logic [PINS-1:0] pol_a  [NUM_PORTS];
    logic [PINS-1:0] edg_a  [NUM_PORTS];
    logic [PINS-1:0] any_a  [NUM_PORTS];
    logic [PINS-1:0] evt_a  [NUM_PORTS];

    assign kind             = reg_kind_e'(bus_addr[7:4]);
    assign port_sel         = bus_addr[2 +: PORT_W];
    assign unused_addr_bits = ^{bus_addr[1:0]};

    gpio_in_sync #(
        .WIDTH  (TOTAL),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (pin_in),
        .sync_q    (pin_now),
        .sync_prev (pin_last)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_PORTS; g++) begin : g_port
            logic wr_hit;
            assign wr_hit = bus_wr_en && (port_sel == PORT_W'(g));

            gpio_trig_detect #(.PINS(PINS)) u_det (
                .cur  (pin_now[g*PINS +: PINS]),
                .prev (pin_last[g*PINS +: PINS]),
                .pol  (pol_a[g]),
                .edg  (edg_a[g]),
                .anyc (any_a[g]),
                .evt  (evt_a[g])
            );

            gpio_port_regs #(.PINS(PINS), .DATA_W(DATA_W)) u_regs (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_hit  (wr_hit),
                .kind    (kind),
                .wdata   (bus_wdata),
                .evt     (evt_a[g]),
                .mode_q  (mode_a[g]),
                .drive_q (drv_a[g]),
                .level_q (lvl_a[g]),
                .enab_q  (enb_a[g]),
                .stat_q  (sta_a[g]),
                .pol_q   (pol_a[g]),
                .edg_q   (edg_a[g]),
                .anyc_q  (any_a[g])
            );

            assign pin_gpio_mode[g*PINS +: PINS] = mode_a[g];
            assign pin_oe[g*PINS +: PINS]        = drv_a[g];
            assign pin_out[g*PINS +: PINS]       = lvl_a[g];
            assign sta_flat[g*PINS +: PINS]      = sta_a[g];
            assign enb_flat[g*PINS +: PINS]      = enb_a[g];
            assign evt_flat[g*PINS +: PINS]      = evt_a[g];
        end
    endgenerate

    // Read mux: select the addressed register of the addressed port.
    always_comb begin
        bus_rdata = '0;
        case (kind)
            RK_MODE,  RK_MODE_M:  bus_rdata[PINS-1:0]   = mode_a[port_sel];
            RK_DRIVE, RK_DRIVE_M: bus_rdata[PINS-1:0]   = drv_a[port_sel];
            RK_LEVEL, RK_LEVEL_M: bus_rdata[PINS-1:0]   = lvl_a[port_sel];
            RK_INPUT:             bus_rdata[PINS-1:0]   = pin_now[port_sel*PINS +: PINS];
            RK_STATUS, RK_STAT_M: bus_rdata[PINS-1:0]   = sta_a[port_sel];
            RK_ENABLE, RK_ENAB_M: bus_rdata[PINS-1:0]   = enb_a[port_sel];
            RK_TRIG,  RK_TRIG_M:  bus_rdata[3*PINS-1:0] = {any_a[port_sel], edg_a[port_sel], pol_a[port_sel]};
            default:              bus_rdata = '0;
        endcase
    end

    // Bank interrupt: any pin both flagged and enabled.
    assign bank_irq = |(sta_flat & enb_flat);

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
`timescale 1ns/1ps
// Cycle-level checker for gpio_bank_ctrl, watching port 0 and the bus.
// Assumes the fixed address layout: kind in [7:4], port in [3:2].
module gpio_bank_ctrl_chk #(
    parameter int NUM_PORTS = 4,
    parameter int PINS      = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr_en,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic [NUM_PORTS*PINS-1:0] pin_in,
    input logic [NUM_PORTS*PINS-1:0] pin_out,
    input logic [NUM_PORTS*PINS-1:0] sta_flat,
    input logic [NUM_PORTS*PINS-1:0] evt_flat
);

    logic [1:0] live_cnt;

    // Count clock edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)               live_cnt <= '0;
        else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
    end

    assert_input_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 2'd2 && bus_addr == 8'h30)
        |-> (bus_rdata[PINS-1:0] == $past(pin_in[PINS-1:0], 2)) && (bus_rdata[DATA_W-1:PINS] == '0));

    assert_level_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 8'h20) |=> (pin_out[PINS-1:0] == $past(bus_wdata[PINS-1:0])));

    assert_masked_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 8'hA0)
        |=> (pin_out[PINS-1:0] ==
             (($past(pin_out[PINS-1:0]) & ~$past(bus_wdata[2*PINS-1:PINS]))
              | ($past(bus_wdata[PINS-1:0]) & $past(bus_wdata[2*PINS-1:PINS])))));

    assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 8'h70 && bus_wdata[0] && !evt_flat[0]) |=> !sta_flat[0]);

    assert_status_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sta_flat[0])
        |-> ($past(evt_flat[0]) || $past(bus_wr_en && bus_addr == 8'hC0 && bus_wdata[PINS] && bus_wdata[0])));

    assert_hole_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[7:4] == 4'hB || bus_addr[7:4] == 4'hF) |-> (bus_rdata == '0));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PINS      (PINS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .sta_flat  (sta_flat),
    .evt_flat  (evt_flat)
);

// File: tb/gpio_bank_ctrl_tb.sv
`timescale 1ns/1ps
// Self-checking bench: register vector table, then directed interrupt tests.
module gpio_bank_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pin_gpio_mode;
    logic        bank_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_bank_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr_en     (bus_wr_en),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .pin_in        (pin_in),
        .pin_out       (pin_out),
        .pin_oe        (pin_oe),
        .pin_gpio_mode (pin_gpio_mode),
        .bank_irq      (bank_irq)
    );

    typedef struct packed {
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  raddr;
        logic [31:0] expv;
        logic [23:0] tag;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 32'h0000_00A5, 8'h00, 32'h0000_00A5, "R2 "},
        '{8'h14, 32'h0000_003C, 8'h14, 32'h0000_003C, "R2 "},
        '{8'h28, 32'h0000_0081, 8'h28, 32'h0000_0081, "R2 "},
        '{8'h6C, 32'hFFFF_FFFF, 8'h6C, 32'h00FF_FFFF, "R12"},
        '{8'h80, 32'h0000_F00F, 8'h00, 32'h0000_0005, "R10"},
        '{8'hEC, 32'hFF01_0203, 8'h6C, 32'h0001_0203, "R11"},
        '{8'hEC, 32'h0FFF_FFFF, 8'h6C, 32'h000F_0F0F, "R11"},
        '{8'h6C, 32'h0000_0000, 8'h6C, 32'h0000_0000, "R2 "},
        '{8'hB0, 32'hFFFF_FFFF, 8'hB0, 32'h0000_0000, "R12"},
        '{8'hF0, 32'hFFFF_FFFF, 8'hF0, 32'h0000_0000, "R12"},
        '{8'h30, 32'h0000_00FF, 8'h30, 32'h0000_0000, "R4 "},
        '{8'h70, 32'h0000_00FF, 8'h70, 32'h0000_0000, "R8 "},
        '{8'h90, 32'h0000_0F0F, 8'h10, 32'h0000_000F, "R10"},
        '{8'hA4, 32'h0000_FFAA, 8'h24, 32'h0000_00AA, "R10"}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic read_check(input string tag, input logic [7:0] a, input logic [31:0] expv);
        bus_addr = a;
        #0.2;
        check(tag, bus_rdata, expv);
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #0.2;

        // R1: reset state
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_gpio_mode", pin_gpio_mode, 32'h0);
        check("R1 bank_irq", {31'h0, bank_irq}, 32'h0);
        read_check("R1 mode", 8'h00, 32'h0);
        read_check("R1 trig", 8'h60, 32'h0);
        read_check("R1 enable", 8'h54, 32'h0);

        // Vector table: write, then read back
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VECS[i].waddr, VECS[i].wdata);
            read_check($sformatf("%s vec%0d", VECS[i].tag, i), VECS[i].raddr, VECS[i].expv);
        end

        // R3: register contents on the pin vectors
        check("R3 mode port0", {24'h0, pin_gpio_mode[7:0]}, 32'h05);
        check("R3 oe port1", {24'h0, pin_oe[15:8]}, 32'h3C);
        check("R3 oe port0", {24'h0, pin_oe[7:0]}, 32'h0F);
        check("R3 out port2", {24'h0, pin_out[23:16]}, 32'h81);
        check("R3 out port1", {24'h0, pin_out[15:8]}, 32'hAA);

        // R4: input latency of two edges
        @(negedge clk);
        pin_in[15:8] = 8'h5A;
        edges(1);
        read_check("R4 one edge", 8'h34, 32'h00);
        edges(1);
        read_check("R4 two edges", 8'h34, 32'h5A);

        // R5 and R8: level-high trigger re-sets status despite clear
        bus_write(8'h64, 32'h0000_00FF);
        bus_write(8'h74, 32'h0000_00FF);
        read_check("R5 level status", 8'h44, 32'h5A);

        // R9: irq follows status AND enable
        bus_write(8'h54, 32'h0000_0002);
        check("R9 irq enabled", {31'h0, bank_irq}, 32'h1);
        bus_write(8'h54, 32'h0000_0004);
        check("R9 irq masked", {31'h0, bank_irq}, 32'h0);
        read_check("R9 status kept", 8'h44, 32'h5A);

        // R6: single-edge mode on port 2, pin0 rising, pin1 falling
        bus_write(8'h68, 32'h0000_FF01);
        bus_write(8'h78, 32'h0000_00FF);
        read_check("R6 cleared", 8'h48, 32'h00);
        pin_in[17:16] = 2'b11;
        edges(2);
        read_check("R6 before third edge", 8'h48, 32'h00);
        edges(1);
        read_check("R6 rising only", 8'h48, 32'h01);
        @(negedge clk);
        pin_in[17:16] = 2'b00;
        edges(3);
        read_check("R6 falling added", 8'h48, 32'h03);

        // R8: zeros have no effect, ones clear
        bus_write(8'h78, 32'h0000_0000);
        read_check("R8 zero write", 8'h48, 32'h03);
        bus_write(8'h78, 32'h0000_0002);
        read_check("R8 one clears", 8'h48, 32'h01);

        // R10: masked status write sets one bit only
        bus_write(8'hC8, 32'h0000_8080);
        read_check("R10 masked status", 8'h48, 32'h81);

        // R7: any-change mode on port 3
        bus_write(8'h6C, 32'h00FF_FF00);
        bus_write(8'h7C, 32'h0000_00FF);
        read_check("R7 cleared", 8'h4C, 32'h00);
        pin_in[24] = 1'b1;
        edges(3);
        read_check("R7 rise", 8'h4C, 32'h01);
        bus_write(8'h7C, 32'h0000_0001);
        read_check("R7 cleared again", 8'h4C, 32'h00);
        pin_in[24] = 1'b0;
        edges(3);
        read_check("R7 fall", 8'h4C, 32'h01);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule